// File: doc/BRIEF.md
# Instruction Fetch Block Buffer

This block keeps a handful of recently fetched instruction blocks close to the fetch stage. Each block is one cache line of instruction words. It is tagged by an address-space identifier and by the block-aligned part of the fetch address. A fetch request first runs a lookup. On a hit, the request reserves the block, so it can later take its instruction word from the buffer instead of going to memory. A later consume returns the word and releases the reservation. A squash releases a reservation when the request is cancelled before it consumes.

The miss tracker hands completed lines to the insert port. When a free slot exists, the line goes there. Otherwise the line replaces the least recently used block that has no outstanding reservation. If every block is reserved, the insert is refused and the tracker retries. Each entry carries an age rank that is updated in a single cycle. Only one of the four request ports is served per clock.

Top module: `instr_block_buffer`

## Requirements
- R1: A lookup hits only when the stored address-space ID and the block-aligned address (address bits above the block offset) both equal the request. A lookup that misses completes with `lk_hit`=0 and changes nothing.
- R2: A lookup hit completes with `lk_hit`=1 and adds one to that entry's reservation count. If the count is already at its maximum, the lookup does not complete (`lk_done`=0) and must be retried.
- R3: A consume hit returns on `cs_word` the word whose index is the address's byte offset within the block divided by the word size in bytes (address bits [3:2] with the defaults). Word i sits at bits [32i+31:32i] of the inserted block.
- R4: A consume hit lowers the entry's count by one and makes the entry the most recently used.
- R5: A consume whose block is not in the buffer does not complete (`cs_done`=0) and changes nothing.
- R6: An insert uses a free slot while one exists. Once the buffer is full, it replaces the least recently used entry whose count is zero. If no entry has a zero count, the insert is refused (`ins_done`=0) and the buffer is left unchanged.
- R7: An inserted block becomes the most recently used entry, and its count is loaded from `ins_cnt`.
- R8: A squash always completes. When it matches a buffered entry, that entry's count drops by one. When it matches nothing, it has no effect.
- R9: A consume or a squash that hits an entry whose count is zero leaves the count at zero and sets `err_underflow`. That flag then stays set until reset.
- R10: When several ports are valid in the same cycle, only the highest-priority one is served. The order, from highest, is insert, squash, consume, lookup. At most one `*_done` is high in any cycle.
- R11: Reset empties the buffer and clears `err_underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_addr | input | ADDR_W | Lookup fetch address |
| lk_done | output | 1 | Lookup served this cycle |
| lk_hit | output | 1 | Lookup found the block and reserved it |
| cs_valid | input | 1 | Consume request |
| cs_asid | input | ASID_W | Consume address-space ID |
| cs_addr | input | ADDR_W | Consume fetch address |
| cs_done | output | 1 | Consume served; `cs_word` is valid |
| cs_word | output | WORD_W | Selected instruction word |
| ins_valid | input | 1 | Insert request from the miss tracker |
| ins_asid | input | ASID_W | Address-space ID of the new block |
| ins_addr | input | ADDR_W | Address inside the new block |
| ins_data | input | WORD_W*WORDS | Block contents, word 0 in the low bits |
| ins_cnt | input | CNT_W | Reservations still waiting on the new block |
| ins_done | output | 1 | Block written this cycle |
| sq_valid | input | 1 | Squash request |
| sq_asid | input | ASID_W | Squash address-space ID |
| sq_addr | input | ADDR_W | Squash fetch address |
| sq_done | output | 1 | Squash served |
| err_underflow | output | 1 | Sticky flag: a release found a zero count |

## Verification
The hardest state to reach from the ports is a full buffer in which the least recently used entry is still reserved. That is the case where the victim must skip ahead to an older-but-free entry or refuse the insert. The stimulus reaches it in a few steps. It fills all slots, places a lookup reservation on the oldest block, and then reorders recency with a lookup-plus-consume pair. Each eviction is observed afterwards by probing which blocks still hit. A second run fills every slot with nonzero counts, checks the refusal, and then frees exactly one entry with a squash. The count itself has no port, so it is read indirectly: through when the underflow flag sets and through which entry can be evicted.

// File: rtl/fbb_pkg.sv
// Package: shared types of the instruction fetch block buffer.
// Assumes nothing beyond IEEE 1800-2017.
package fbb_pkg;
    // Which request port wins the single update slot of a cycle
    typedef enum logic [2:0] {
        GNT_NONE = 3'd0,
        GNT_INS  = 3'd1,
        GNT_SQ   = 3'd2,
        GNT_CS   = 3'd3,
        GNT_LK   = 3'd4
    } gnt_e;
endpackage

// File: rtl/fbb_match.sv
// Module: fbb_match
// Compares one request tag (address-space ID plus block address) against
// every entry in parallel and returns a hit flag and the matching index.
// Assumes the buffer never holds two valid entries with the same tag.
module fbb_match #(
    parameter int N      = 4,
    parameter int ASID_W = 4,
    parameter int TAG_W  = 12
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [N-1:0][TAG_W-1:0]  ent_tag,
    input  logic [ASID_W-1:0]        req_asid,
    input  logic [TAG_W-1:0]         req_tag,
    output logic                     hit,
    output logic [$clog2(N)-1:0]     idx
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0] eq;

    // Per-entry equality of both tag fields
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_asid[g] == req_asid) &&
                       (ent_tag[g] == req_tag);
    end

    // Encode the (single) matching entry into an index
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fbb_age.sv
// Module: fbb_age
// Holds a recency rank per entry (0 = most recent, N-1 = oldest) as a
// permutation, updates it in one cycle when an entry is touched, and picks
// the oldest entry among the offered replacement candidates.
// Assumes at most one touch per cycle.
module fbb_age #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch_en,
    input  logic [$clog2(N)-1:0] touch_idx,
    input  logic [N-1:0]         cand,
    output logic [$clog2(N)-1:0] victim_idx,
    output logic                 victim_ok
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0][IDX_W-1:0] age_q;
    logic [N-1:0]            rank_cover;
    logic [IDX_W-1:0]        best_age;

    // Rank update: touched entry to 0, younger entries age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + IDX_W'(1);
            end
        end
    end

    // Victim choice: oldest rank among the candidates
    always_comb begin
        victim_ok  = 1'b0;
        victim_idx = '0;
        best_age   = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!victim_ok || age_q[i] > best_age)) begin
                victim_ok  = 1'b1;
                victim_idx = IDX_W'(i);
                best_age   = age_q[i];
            end
        end
    end

    // Coverage map of ranks, used only by the permutation check
    always_comb begin
        rank_cover = '0;
        for (int i = 0; i < N; i++) rank_cover[age_q[i]] = 1'b1;
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        rank_cover == {N{1'b1}}); // R4
    AST_TOUCH_TO_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0); // R7
endmodule

// File: rtl/instr_block_buffer.sv
// Module: instr_block_buffer
// Buffer of recently fetched instruction blocks with per-entry reservation
// counts. Serves one of four ports per cycle (insert > squash > consume >
// lookup); replies are combinational, state changes at the clock edge.
// Assumes the miss tracker never inserts a block that is already present.
module instr_block_buffer
    import fbb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ASID_W  = 4,
    parameter int ADDR_W  = 16,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    parameter int CNT_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_done,
    output logic                    lk_hit,
    input  logic                    cs_valid,
    input  logic [ASID_W-1:0]       cs_asid,
    input  logic [ADDR_W-1:0]       cs_addr,
    output logic                    cs_done,
    output logic [WORD_W-1:0]       cs_word,
    input  logic                    ins_valid,
    input  logic [ASID_W-1:0]       ins_asid,
    input  logic [ADDR_W-1:0]       ins_addr,
    input  logic [WORD_W*WORDS-1:0] ins_data,
    input  logic [CNT_W-1:0]        ins_cnt,
    output logic                    ins_done,
    input  logic                    sq_valid,
    input  logic [ASID_W-1:0]       sq_asid,
    input  logic [ADDR_W-1:0]       sq_addr,
    output logic                    sq_done,
    output logic                    err_underflow
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSH    = $clog2(WORD_W / 8);
    localparam int OFF_W  = WSEL_W + BSH;
    localparam int TAG_W  = ADDR_W - OFF_W;

    // Entry storage
    logic [ENTRIES-1:0]                         valid_q;
    logic [ENTRIES-1:0][ASID_W-1:0]             asid_q;
    logic [ENTRIES-1:0][TAG_W-1:0]              tag_q;
    logic [ENTRIES-1:0][CNT_W-1:0]              cnt_q;
    logic [ENTRIES-1:0][WORDS-1:0][WORD_W-1:0]  data_q;
    logic                                       err_q;

    logic             lk_match, cs_match, sq_match;
    logic [IDX_W-1:0] lk_idx, cs_idx, sq_idx, victim_idx;
    logic [WSEL_W-1:0] cs_wsel;
    logic             victim_ok, full, lk_sat, touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [ENTRIES-1:0] cand;
    gnt_e             gnt;

    fbb_match #(.N(ENTRIES), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_lk_match (
        .ent_valid(valid_q), .ent_asid(asid_q), .ent_tag(tag_q),
        .req_asid(lk_asid), .req_tag(lk_addr[ADDR_W-1:OFF_W]),
        .hit(lk_match), .idx(lk_idx));

    fbb_match #(.N(ENTRIES), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_cs_match (
        .ent_valid(valid_q), .ent_asid(asid_q), .ent_tag(tag_q),
        .req_asid(cs_asid), .req_tag(cs_addr[ADDR_W-1:OFF_W]),
        .hit(cs_match), .idx(cs_idx));

    fbb_match #(.N(ENTRIES), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_sq_match (
        .ent_valid(valid_q), .ent_asid(asid_q), .ent_tag(tag_q),
        .req_asid(sq_asid), .req_tag(sq_addr[ADDR_W-1:OFF_W]),
        .hit(sq_match), .idx(sq_idx));

    // Replacement candidates: free slots first, else unreserved entries
    always_comb begin
        full = &valid_q;
        for (int i = 0; i < ENTRIES; i++)
            cand[i] = full ? (cnt_q[i] == '0) : !valid_q[i];
    end

    fbb_age #(.N(ENTRIES)) u_age (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .cand(cand), .victim_idx(victim_idx), .victim_ok(victim_ok));

    // Fixed-priority grant of the single update slot
    always_comb begin
        if (ins_valid)     gnt = GNT_INS;
        else if (sq_valid) gnt = GNT_SQ;
        else if (cs_valid) gnt = GNT_CS;
        else if (lk_valid) gnt = GNT_LK;
        else               gnt = GNT_NONE;
    end

    // Port replies and recency touch for this cycle
    always_comb begin
        lk_sat    = lk_match && (cnt_q[lk_idx] == {CNT_W{1'b1}});
        ins_done  = (gnt == GNT_INS) && victim_ok;
        sq_done   = (gnt == GNT_SQ);
        cs_done   = (gnt == GNT_CS) && cs_match;
        lk_done   = (gnt == GNT_LK) && !lk_sat;
        lk_hit    = lk_done && lk_match;
        cs_wsel   = cs_addr[OFF_W-1:BSH];
        cs_word   = data_q[cs_idx][cs_wsel];
        touch_en  = ins_done || cs_done;
        touch_idx = ins_done ? victim_idx : cs_idx;
    end

    assign err_underflow = err_q;

    // Entry state and sticky error update for the granted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            asid_q  <= '0;
            tag_q   <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (gnt)
                GNT_INS: if (victim_ok) begin
                    valid_q[victim_idx] <= 1'b1;
                    asid_q[victim_idx]  <= ins_asid;
                    tag_q[victim_idx]   <= ins_addr[ADDR_W-1:OFF_W];
                    cnt_q[victim_idx]   <= ins_cnt;
                    data_q[victim_idx]  <= ins_data;
                end
                GNT_SQ: if (sq_match) begin
                    if (cnt_q[sq_idx] == '0) err_q <= 1'b1;
                    else cnt_q[sq_idx] <= cnt_q[sq_idx] - CNT_W'(1);
                end
                GNT_CS: if (cs_match) begin
                    if (cnt_q[cs_idx] == '0) err_q <= 1'b1;
                    else cnt_q[cs_idx] <= cnt_q[cs_idx] - CNT_W'(1);
                end
                GNT_LK: if (lk_match && !lk_sat) begin
                    cnt_q[lk_idx] <= cnt_q[lk_idx] + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    AST_SINGLE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ins_done, sq_done, cs_done, lk_done})); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow); // R9
    AST_LOOKUP_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> cnt_q[$past(lk_idx)] == $past(cnt_q[lk_idx]) + CNT_W'(1)); // R2
    AST_CONSUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_done && cnt_q[cs_idx] != '0) |=>
        cnt_q[$past(cs_idx)] == $past(cnt_q[cs_idx]) - CNT_W'(1)); // R4
    AST_VICTIM_UNRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && full) |-> cnt_q[victim_idx] == '0); // R6
    AST_INSERT_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_done |=> valid_q[$past(victim_idx)] &&
                     cnt_q[$past(victim_idx)] == $past(ins_cnt)); // R7
endmodule

// File: tb/sim_instr_block_buffer.sv
module sim_instr_block_buffer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 0, cs_valid = 0, ins_valid = 0, sq_valid = 0;
    logic [3:0]   lk_asid = 0, cs_asid = 0, ins_asid = 0, sq_asid = 0;
    logic [15:0]  lk_addr = 0, cs_addr = 0, ins_addr = 0, sq_addr = 0;
    logic [127:0] ins_data = '0;
    logic [3:0]   ins_cnt = 0;
    logic         lk_done, lk_hit, cs_done, ins_done, sq_done, err_underflow;
    logic [31:0]  cs_word;
    int           n_chk = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    instr_block_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr),
        .lk_done(lk_done), .lk_hit(lk_hit),
        .cs_valid(cs_valid), .cs_asid(cs_asid), .cs_addr(cs_addr),
        .cs_done(cs_done), .cs_word(cs_word),
        .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_addr(ins_addr),
        .ins_data(ins_data), .ins_cnt(ins_cnt), .ins_done(ins_done),
        .sq_valid(sq_valid), .sq_asid(sq_asid), .sq_addr(sq_addr),
        .sq_done(sq_done), .err_underflow(err_underflow));

    // Word i of a block: {asid, block address, zeros, i}
    function automatic logic [31:0] mkword(logic [3:0] a, logic [15:0] ad, logic [1:0] i);
        return {a, ad[15:4], 12'h000, 2'b00, i};
    endfunction

    function automatic logic [127:0] mkblk(logic [3:0] a, logic [15:0] ad);
        logic [127:0] b;
        for (int i = 0; i < 4; i++) b[i*32 +: 32] = mkword(a, ad, 2'(i));
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of requests at the falling edge, settle, leave outputs to sample
    task automatic apply(input logic i, input logic s, input logic c, input logic l,
                         input logic [3:0] a, input logic [15:0] ad, input logic [3:0] n);
        @(negedge clk);
        ins_valid = i; sq_valid = s; cs_valid = c; lk_valid = l;
        ins_asid = a; sq_asid = a; cs_asid = a; lk_asid = a;
        ins_addr = ad; sq_addr = ad; cs_addr = ad; lk_addr = ad;
        ins_data = mkblk(a, ad); ins_cnt = n;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ins_valid = 0; sq_valid = 0; cs_valid = 0; lk_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic lk_expect(input string req, input logic [3:0] a, input logic [15:0] ad,
                             input logic exp_hit);
        apply(0, 0, 0, 1, a, ad, 0);
        chk(req, {31'd0, lk_hit}, {31'd0, exp_hit});
    endtask

    task automatic ins_expect(input string req, input logic [3:0] a, input logic [15:0] ad,
                              input logic [3:0] n, input logic exp_done);
        apply(1, 0, 0, 0, a, ad, n);
        chk(req, {31'd0, ins_done}, {31'd0, exp_done});
    endtask

    // op: 0 insert, 1 squash, 2 consume, 3 lookup
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  asid;
        logic [15:0] addr;
        logic [3:0]  cnt;
        logic        e_done;
        logic        e_hit;
        logic        e_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 4'd1, 16'h0100, 4'd0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 empty miss
        '{2'd0, 4'd1, 16'h0100, 4'd1, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 free slot
        '{2'd3, 4'd1, 16'h0108, 4'd0, 1'b1, 1'b1, 1'b0, 4'd2}, // R2 hit, count 2
        '{2'd3, 4'd2, 16'h0100, 4'd0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 wrong asid
        '{2'd3, 4'd1, 16'h0110, 4'd0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 wrong block
        '{2'd2, 4'd1, 16'h0108, 4'd0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 word 2
        '{2'd2, 4'd1, 16'h010C, 4'd0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 word 3
        '{2'd2, 4'd1, 16'h0104, 4'd0, 1'b1, 1'b0, 1'b1, 4'd9}, // R9 underflow
        '{2'd2, 4'd3, 16'h0200, 4'd0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 absent block
        '{2'd1, 4'd3, 16'h0200, 4'd0, 1'b1, 1'b0, 1'b1, 4'd8}  // R8 no match
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R11: reset state
        #2;
        chk("R11 err after reset", {31'd0, err_underflow}, 32'd0);
        apply(0, 0, 1, 0, 4'd1, 16'h0100, 0);
        chk("R11 consume on empty", {31'd0, cs_done}, 32'd0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            logic  d;
            tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
            apply(VEC[k].op == 2'd0, VEC[k].op == 2'd1, VEC[k].op == 2'd2,
                  VEC[k].op == 2'd3, VEC[k].asid, VEC[k].addr, VEC[k].cnt);
            case (VEC[k].op)
                2'd0: d = ins_done;
                2'd1: d = sq_done;
                2'd2: d = cs_done;
                default: d = lk_done;
            endcase
            chk(tag, {31'd0, d}, {31'd0, VEC[k].e_done});
            if (VEC[k].op == 2'd3)
                chk(tag, {31'd0, lk_hit}, {31'd0, VEC[k].e_hit});
            if (VEC[k].op == 2'd2 && VEC[k].e_done)
                chk(tag, cs_word, mkword(VEC[k].asid, VEC[k].addr, VEC[k].addr[3:2]));
            @(negedge clk);
            ins_valid = 0; sq_valid = 0; cs_valid = 0; lk_valid = 0;
            #2;
            chk(tag, {31'd0, err_underflow}, {31'd0, VEC[k].e_err});
        end

        // R11: reset clears the flag and the contents
        do_reset();
        #2;
        chk("R11 err cleared", {31'd0, err_underflow}, 32'd0);
        lk_expect("R11 block gone", 4'd1, 16'h0100, 1'b0);

        // R6/R4: replacement skips a reserved oldest entry and follows recency
        for (int b = 1; b <= 4; b++) ins_expect("R6 fill", 4'd1, 16'(b * 16'h1000), 0, 1'b1);
        lk_expect("R2 pin oldest", 4'd1, 16'h1000, 1'b1);
        ins_expect("R6 insert full", 4'd1, 16'h5000, 0, 1'b1);
        lk_expect("R6 second oldest evicted", 4'd1, 16'h2000, 1'b0);
        lk_expect("R6 pinned oldest kept", 4'd1, 16'h1000, 1'b1);
        lk_expect("R2 reserve B2", 4'd1, 16'h3000, 1'b1);
        apply(0, 0, 1, 0, 4'd1, 16'h3004, 0);
        chk("R4 consume B2", {31'd0, cs_done}, 32'd1);
        chk("R3 consume B2 word", cs_word, mkword(4'd1, 16'h3004, 2'd1));
        ins_expect("R6 insert after touch", 4'd1, 16'h6000, 0, 1'b1);
        lk_expect("R4 oldest free evicted", 4'd1, 16'h4000, 1'b0);
        lk_expect("R7 new block present", 4'd1, 16'h6000, 1'b1);
        lk_expect("R4 touched block kept", 4'd1, 16'h3000, 1'b1);
        lk_expect("R6 newer block kept", 4'd1, 16'h5000, 1'b1);
        #0 chk("R9 no false error", {31'd0, err_underflow}, 32'd0);

        // R6: every entry reserved refuses the insert
        do_reset();
        for (int b = 1; b <= 4; b++) ins_expect("R7 fill counted", 4'd2, 16'(b * 16'h0400), 1, 1'b1);
        ins_expect("R6 all pinned refused", 4'd2, 16'h2000, 0, 1'b0);
        lk_expect("R6 refused not stored", 4'd2, 16'h2000, 1'b0);
        apply(0, 1, 0, 0, 4'd2, 16'h0800, 0);
        chk("R8 squash match", {31'd0, sq_done}, 32'd1);
        ins_expect("R6 insert after squash", 4'd2, 16'h2000, 0, 1'b1);
        lk_expect("R8 squashed entry evicted", 4'd2, 16'h0800, 1'b0);
        apply(0, 1, 0, 0, 4'd2, 16'h0400, 0);
        @(negedge clk); sq_valid = 0; #2;
        chk("R8 release to zero no error", {31'd0, err_underflow}, 32'd0);
        apply(0, 1, 0, 0, 4'd2, 16'h0400, 0);
        @(negedge clk); sq_valid = 0; #2;
        chk("R9 squash underflow", {31'd0, err_underflow}, 32'd1);
        apply(0, 0, 1, 0, 4'd2, 16'h0408, 0);
        chk("R9 count held at zero", {31'd0, cs_done}, 32'd1);

        // R10: fixed priority between simultaneous requests
        do_reset();
        apply(1, 1, 1, 1, 4'd5, 16'h7000, 2);
        chk("R10 insert wins", {28'd0, ins_done, sq_done, cs_done, lk_done}, 32'b1000);
        apply(0, 1, 1, 1, 4'd5, 16'h7000, 0);
        chk("R10 squash wins", {28'd0, ins_done, sq_done, cs_done, lk_done}, 32'b0100);
        apply(0, 0, 1, 1, 4'd5, 16'h700C, 0);
        chk("R10 consume wins", {28'd0, ins_done, sq_done, cs_done, lk_done}, 32'b0010);
        chk("R3 word at index 3", cs_word, mkword(4'd5, 16'h700C, 2'd3));
        apply(0, 0, 1, 0, 4'd5, 16'h7000, 0);
        @(negedge clk); cs_valid = 0; #2;
        chk("R9 count reached zero", {31'd0, err_underflow}, 32'd1);

        // R2: saturated count refuses the lookup
        do_reset();
        ins_expect("R7 insert at max", 4'd6, 16'h8000, 4'hF, 1'b1);
        apply(0, 0, 0, 1, 4'd6, 16'h8000, 0);
        chk("R2 saturated lookup", {30'd0, lk_done, lk_hit}, 32'b00);
        apply(0, 0, 1, 0, 4'd6, 16'h8000, 0);
        chk("R4 consume saturated", {31'd0, cs_done}, 32'd1);
        lk_expect("R2 lookup after release", 4'd6, 16'h8000, 1'b1);

        @(negedge clk);
        ins_valid = 0; sq_valid = 0; cs_valid = 0; lk_valid = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule